// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds in-flight stores for an out-of-order core. Dispatch claims entries in program order through a valid/ready port and gets back a pointer tag for each store. The tag's low bits name the entry, and its top bit flips on every pass around the ring. When the store executes, it writes its address and data into that entry, and the two may arrive in separate cycles. Nothing leaves the queue for memory until the retirement pulse has marked the store committed. Committed stores then leave from the oldest end, one per cycle, over a valid/ready write port. That port follows normal stream rules: the payload holds steady while valid is high and ready is low, and the head entry frees only on the cycle both are high.

A load lookup presents an address and the load's position. The position is the tag that dispatch would have handed out next when the load was issued, so every store whose tag comes before it is older than the load. In the same cycle the queue scans the older entries whose addresses are known. It reports a hit with data, a stall, or a miss. The result comes from the youngest older store whose full-word address matches exactly. A flush input moves the allocation pointer back to a given tag. Every entry from that tag onward is dropped, and those entries never reach memory.

Top module: `stq_fwd`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `alloc_ready`=1, `mem_valid`=0 and `alloc_tag`=0.
- R2: A tag is PTR_W = log2(DEPTH)+1 bits wide: the low bits are the entry index and the top bit is the wrap bit. Each allocation handshake returns the current tag on `alloc_tag` and then increments it by one. With DEPTH entries in use, `full`=1 and `alloc_ready`=0, and a request made while full changes nothing.
- R3: A store is not presented on the memory port until a `retire_valid` pulse has committed it. Each pulse commits the oldest uncommitted store, and a pulse is ignored when no uncommitted store exists.
- R4: The memory port presents committed stores oldest first, showing that entry's address and data. The payload stays stable while `mem_ready` is low. The head advances by exactly one on each cycle where `mem_valid` and `mem_ready` are both high.
- R5: In the same cycle as the request, a lookup considers only entries whose address is known, whose tag is older than `ld_pos`, and whose address equals `ld_addr` in every bit. If no entry qualifies, both `ld_hit` and `ld_stall` are 0 and `ld_data` is 0.
- R6: When several qualifying stores exist, `ld_hit`=1 and `ld_data` carries the data of the youngest of them.
- R7: If the youngest qualifying store has no data yet, `ld_stall`=1, `ld_hit`=0 and `ld_data`=0, even when an older match does have data.
- R8: Age is measured as a tag distance from the head, so older and younger are judged correctly across the entry-index wrap. A `ld_pos` whose distance from the head exceeds the occupancy means every older store has already drained, and the lookup misses.
- R9: A flush sets the allocation pointer to `flush_ptr` on the next edge. Allocation is refused during the flush cycle. Entries from `flush_ptr` onward are never forwarded and never drained, and later allocations reuse those tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests one entry |
| alloc_ready | output | 1 | Entry can be granted this cycle |
| alloc_tag | output | PTR_W | Tag given to the store granted this cycle |
| full | output | 1 | All entries in use |
| empty | output | 1 | No entries in use |
| st_idx | input | IDX_W | Entry written by an executing store |
| st_addr_valid | input | 1 | Write the store address |
| st_addr | input | ADDR_W | Store address |
| st_data_valid | input | 1 | Write the store data |
| st_data | input | DATA_W | Store data |
| retire_valid | input | 1 | Commit the oldest uncommitted store |
| flush_valid | input | 1 | Discard entries from flush_ptr onward |
| flush_ptr | input | PTR_W | First discarded tag |
| ld_valid | input | 1 | Lookup request |
| ld_addr | input | ADDR_W | Load address |
| ld_pos | input | PTR_W | Load position: first tag younger than the load |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_stall | output | 1 | Youngest older match lacks data |
| ld_data | output | DATA_W | Forwarded data |
| mem_valid | output | 1 | A committed store is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | ADDR_W | Address of the offered store |
| mem_data | output | DATA_W | Data of the offered store |

## Verification
The assertions assume the core behaves in several ways. Executing stores write only entries that are allocated and not yet committed, and never the entry being allocated in that cycle. Only stores whose address and data are both written get committed. A flush tag always lies between the commit pointer and the allocation pointer. The stimulus keeps to these rules by design. It writes execute results only for entries it has just been granted, and it gives every store address and data before its retirement pulse. Its one flush drops a single uncommitted entry, and it issues no lookup, execute or retirement in the flush cycle.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef enum logic [1:0] {
    LK_MISS  = 2'd0,
    LK_HIT   = 2'd1,
    LK_STALL = 2'd2
  } lk_res_e;
endpackage

// File: rtl/stq_ptrs.sv
module stq_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_valid,
  input  logic             drain_fire,
  input  logic             flush_valid,
  input  logic [PTR_W-1:0] flush_ptr,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] cmt,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] count
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  logic [PTR_W-1:0] pend;

  assign count = tail - head;
  assign pend  = tail - cmt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cmt  <= '0;
      tail <= '0;
    end else begin
      if (drain_fire) head <= head + 1'b1;
      if (retire_valid && pend != '0) cmt <= cmt + 1'b1;
      if (flush_valid) tail <= flush_ptr;
      else if (alloc_fire) tail <= tail + 1'b1;
    end
  end

  // R2: occupancy never exceeds the entry count
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_P);
  // R3: the commit pointer stays inside the occupied range
  a_r3_cmt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt - head) <= count);
  // R4: the head moves only on a memory handshake
  a_r4_head_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (head != $past(head)) |-> $past(drain_fire));
  // R9: flush lands the allocation pointer on the flush tag
  a_r9_flush_sets_tail: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> tail == $past(flush_ptr));
  // R9: a flush never reaches committed stores
  a_r9_flush_range: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (flush_ptr - cmt) <= pend);
endmodule

// File: rtl/stq_entries.sv
module stq_entries #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_fire,
  input  logic [IDX_W-1:0]             alloc_slot,
  input  logic [IDX_W-1:0]             st_idx,
  input  logic                         st_addr_valid,
  input  logic [ADDR_W-1:0]            st_addr,
  input  logic                         st_data_valid,
  input  logic [DATA_W-1:0]            st_data,
  output logic [DEPTH-1:0]             addr_ok,
  output logic [DEPTH-1:0]             data_ok,
  output logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  output logic [DEPTH-1:0][DATA_W-1:0] data_q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic claim, wr_a, wr_d;
    assign claim = alloc_fire && alloc_slot == IDX_W'(i);
    assign wr_a  = st_addr_valid && st_idx == IDX_W'(i);
    assign wr_d  = st_data_valid && st_idx == IDX_W'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_ok[i] <= 1'b0;
        data_ok[i] <= 1'b0;
      end else if (claim) begin
        addr_ok[i] <= 1'b0;
        data_ok[i] <= 1'b0;
      end else begin
        if (wr_a) addr_ok[i] <= 1'b1;
        if (wr_d) data_ok[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_a) addr_q[i] <= st_addr;
      if (wr_d) data_q[i] <= st_data;
    end
  end

  // R2: an execute write never targets the entry being claimed
  a_r2_exec_not_on_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && (st_addr_valid || st_data_valid)) |-> alloc_slot != st_idx);
endmodule

// File: rtl/stq_search.sv
module stq_search
  import stq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PTR_W-1:0]             head,
  input  logic [PTR_W-1:0]             count,
  input  logic                         ld_valid,
  input  logic [ADDR_W-1:0]            ld_addr,
  input  logic [PTR_W-1:0]             ld_pos,
  input  logic [DEPTH-1:0]             addr_ok,
  input  logic [DEPTH-1:0]             data_ok,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_q,
  output logic                         ld_hit,
  output logic                         ld_stall,
  output logic [DATA_W-1:0]            ld_data
);
  logic [PTR_W-1:0]  lim;
  logic [IDX_W-1:0]  slot;
  logic              found, sel_ok;
  logic [DATA_W-1:0] sel_data;
  lk_res_e           res;

  always_comb begin
    lim = ld_pos - head;
    if (lim > count) lim = '0;
    found    = 1'b0;
    sel_ok   = 1'b0;
    sel_data = '0;
    slot     = '0;
    // scan from the oldest entry; later matches are younger and override
    for (int k = 0; k < DEPTH; k++) begin
      slot = head[IDX_W-1:0] + IDX_W'(k);
      if (PTR_W'(k) < lim && addr_ok[slot] && addr_q[slot] == ld_addr) begin
        found    = 1'b1;
        sel_ok   = data_ok[slot];
        sel_data = data_q[slot];
      end
    end
    if (!ld_valid || !found) res = LK_MISS;
    else if (sel_ok)         res = LK_HIT;
    else                     res = LK_STALL;
  end

  assign ld_hit   = res == LK_HIT;
  assign ld_stall = res == LK_STALL;
  assign ld_data  = ld_hit ? sel_data : '0;

  // R5: an empty queue forwards nothing
  a_r5_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !ld_hit && !ld_stall);
endmodule

// File: rtl/stq_fwd.sv
module stq_fwd #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [PTR_W-1:0]  alloc_tag,
  output logic              full,
  output logic              empty,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              st_addr_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_data_valid,
  input  logic [DATA_W-1:0] st_data,
  input  logic              retire_valid,
  input  logic              flush_valid,
  input  logic [PTR_W-1:0]  flush_ptr,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [PTR_W-1:0]  ld_pos,
  output logic              ld_hit,
  output logic              ld_stall,
  output logic [DATA_W-1:0] ld_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [PTR_W-1:0] head, cmt, tail, count;
  logic             alloc_fire, drain_fire;
  logic [DEPTH-1:0] addr_ok, data_ok;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [IDX_W-1:0] head_slot;

  assign full        = count == DEPTH_P;
  assign empty       = count == '0;
  assign alloc_ready = !full && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign head_slot   = head[IDX_W-1:0];
  assign mem_valid   = cmt != head;
  assign drain_fire  = mem_valid && mem_ready;
  assign mem_addr    = addr_q[head_slot];
  assign mem_data    = data_q[head_slot];

  stq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk, .rst_n, .alloc_fire, .retire_valid, .drain_fire,
    .flush_valid, .flush_ptr, .head, .cmt, .tail, .count
  );

  stq_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entries (
    .clk, .rst_n, .alloc_fire, .alloc_slot(tail[IDX_W-1:0]),
    .st_idx, .st_addr_valid, .st_addr, .st_data_valid, .st_data,
    .addr_ok, .data_ok, .addr_q, .data_q
  );

  stq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_search (
    .clk, .rst_n, .head, .count, .ld_valid, .ld_addr, .ld_pos,
    .addr_ok, .data_ok, .addr_q, .data_q, .ld_hit, .ld_stall, .ld_data
  );

  // R3: only executed stores are offered to memory
  a_r3_offer_executed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> addr_ok[head_slot] && data_ok[head_slot]);
  // R4: an unaccepted offer holds its payload
  a_r4_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R2: a full queue refuses allocation and keeps its tag
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush_valid) |=> $stable(alloc_tag));
endmodule

// File: tb/stq_fwd_test.sv
module stq_fwd_test;
  localparam int PW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, alloc_valid, alloc_ready, full, empty;
  logic [PW-1:0] alloc_tag, flush_ptr, ld_pos;
  logic [IW-1:0] st_idx;
  logic st_addr_valid, st_data_valid, retire_valid, flush_valid, ld_valid;
  logic [31:0] st_addr, st_data, ld_addr, ld_data, mem_addr, mem_data;
  logic ld_hit, ld_stall, mem_valid, mem_ready;

  stq_fwd uut (
    .clk, .rst_n, .alloc_valid, .alloc_ready, .alloc_tag, .full, .empty,
    .st_idx, .st_addr_valid, .st_addr, .st_data_valid, .st_data,
    .retire_valid, .flush_valid, .flush_ptr, .ld_valid, .ld_addr, .ld_pos,
    .ld_hit, .ld_stall, .ld_data, .mem_valid, .mem_ready, .mem_addr, .mem_data
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [31:0] exp_addr [8];
  logic [31:0] exp_data [8];

  typedef struct packed {
    logic [31:0] a;
    logic [3:0]  p;
    logic        h;
    logic        s;
    logic [31:0] d;
  } vec_t;

  // entries: 0:100/A0 1:200/B1 2:100/C2 3:100/no data 4:300/E4 5:empty
  localparam vec_t VECS [12] = '{
    '{32'h100, 4'd1, 1'b1, 1'b0, 32'hA0},  // R5 only entry 0 older
    '{32'h100, 4'd2, 1'b1, 1'b0, 32'hA0},  // R5 entry 1 address differs
    '{32'h100, 4'd3, 1'b1, 1'b0, 32'hC2},  // R6 youngest of two
    '{32'h100, 4'd4, 1'b0, 1'b1, 32'h0 },  // R7 youngest lacks data
    '{32'h100, 4'd6, 1'b0, 1'b1, 32'h0 },  // R7
    '{32'h100, 4'd0, 1'b0, 1'b0, 32'h0 },  // R5 nothing older
    '{32'h200, 4'd6, 1'b1, 1'b0, 32'hB1},  // R5
    '{32'h200, 4'd1, 1'b0, 1'b0, 32'h0 },  // R5 match is younger
    '{32'h300, 4'd5, 1'b1, 1'b0, 32'hE4},  // R5
    '{32'h300, 4'd4, 1'b0, 1'b0, 32'h0 },  // R5
    '{32'h104, 4'd6, 1'b0, 1'b0, 32'h0 },  // R5 exact word only
    '{32'h400, 4'd6, 1'b0, 1'b0, 32'h0 }   // R5 no match
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [PW-1:0] exp_tag);
    @(negedge clk);
    alloc_valid = 1'b1;
    #1 check("R2 alloc", {alloc_ready, alloc_tag}, {1'b1, exp_tag});
    @(posedge clk);
    #1 alloc_valid = 1'b0;
  endtask

  task automatic st_exec(input logic [IW-1:0] idx, input logic av, input logic [31:0] a,
                         input logic dv, input logic [31:0] d);
    @(negedge clk);
    st_idx = idx; st_addr_valid = av; st_addr = a; st_data_valid = dv; st_data = d;
    @(posedge clk);
    #1 st_addr_valid = 1'b0; st_data_valid = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] a, input logic [PW-1:0] p,
                        input logic h, input logic s, input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_pos = p;
    #1 check(req, {ld_hit, ld_stall, ld_data}, {h, s, d});
    ld_valid = 1'b0;
  endtask

  task automatic drain(input int nret, input int nexp);
    int got = 0;
    mem_ready = 1'b1;
    for (int c = 0; c < nret + 6; c++) begin
      @(negedge clk);
      if (mem_valid) begin
        if (got < nexp) check("R4 drain order", {mem_addr, mem_data}, {exp_addr[got], exp_data[got]});
        else check("R9 extra drain", {mem_addr, mem_data}, 64'h0);
        got++;
      end
      retire_valid = (c < nret);
    end
    mem_ready = 1'b0;
    retire_valid = 1'b0;
    check("R4 drain count", 64'(got), 64'(nexp));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; alloc_valid = 0; st_idx = '0; st_addr_valid = 0; st_addr = '0;
    st_data_valid = 0; st_data = '0; retire_valid = 0; flush_valid = 0; flush_ptr = '0;
    ld_valid = 0; ld_addr = '0; ld_pos = '0; mem_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", {empty, full, alloc_ready, mem_valid, alloc_tag}, {4'b1010, 4'd0});

    for (int i = 0; i < 6; i++) do_alloc(PW'(i));
    st_exec(3'd0, 1, 32'h100, 1, 32'hA0);
    st_exec(3'd1, 1, 32'h200, 1, 32'hB1);
    st_exec(3'd2, 1, 32'h100, 1, 32'hC2);
    st_exec(3'd3, 1, 32'h100, 0, 32'h0);
    st_exec(3'd4, 1, 32'h300, 1, 32'hE4);
    @(negedge clk);
    check("R3 no write before retire", {mem_valid, empty}, 2'b00);

    for (int v = 0; v < 12; v++)
      lookup("R5 R6 R7 vector", VECS[v].a, VECS[v].p, VECS[v].h, VECS[v].s, VECS[v].d);
    @(negedge clk);
    ld_addr = 32'h100; ld_pos = 4'd6;
    #1 check("R5 no valid no result", {ld_hit, ld_stall, ld_data}, 34'h0);

    st_exec(3'd3, 0, 32'h0, 1, 32'hD3);
    lookup("R6 late data", 32'h100, 4'd6, 1, 0, 32'hD3);

    // R3/R4: one retirement, memory holds off
    @(negedge clk); retire_valid = 1;
    @(posedge clk); #1 retire_valid = 0;
    @(negedge clk);
    check("R3 offer after retire", {mem_valid, mem_addr, mem_data}, {1'b1, 32'h100, 32'hA0});
    @(negedge clk);
    check("R4 hold while not ready", {mem_valid, mem_addr, mem_data}, {1'b1, 32'h100, 32'hA0});
    mem_ready = 1;
    @(posedge clk); #1 mem_ready = 0;
    @(negedge clk);
    check("R4 one per handshake", {mem_valid, empty}, 2'b00);
    lookup("R4 drained entry gone", 32'h100, 4'd2, 0, 0, 32'h0);

    exp_addr[0] = 32'h200; exp_data[0] = 32'hB1;
    exp_addr[1] = 32'h100; exp_data[1] = 32'hC2;
    drain(2, 2);

    // R9: flush drops entry 5
    st_exec(3'd5, 1, 32'h300, 1, 32'hF5);
    lookup("R9 before flush", 32'h300, 4'd6, 1, 0, 32'hF5);
    @(negedge clk);
    flush_valid = 1; flush_ptr = 4'd5; alloc_valid = 1;
    #1 check("R9 alloc refused in flush", 64'(alloc_ready), 64'd0);
    @(posedge clk); #1 flush_valid = 0; alloc_valid = 0;
    @(negedge clk);
    check("R9 tail rewound", 64'(alloc_tag), 64'd5);
    lookup("R9 after flush", 32'h300, 4'd5, 1, 0, 32'hE4);

    // R8: wrap the ring and fill it
    for (int i = 5; i < 11; i++) do_alloc(PW'(i));
    @(negedge clk);
    check("R2 full", {full, alloc_ready, empty}, 3'b100);
    alloc_valid = 1;
    @(posedge clk); #1 alloc_valid = 0;
    @(negedge clk);
    check("R2 request while full ignored", {full, alloc_tag}, {1'b1, 4'd11});
    st_exec(3'd5, 1, 32'h500, 1, 32'h55);
    st_exec(3'd6, 1, 32'h600, 1, 32'h66);
    st_exec(3'd7, 1, 32'h700, 1, 32'h77);
    st_exec(3'd0, 1, 32'h500, 1, 32'h88);
    st_exec(3'd1, 1, 32'h500, 1, 32'h99);
    st_exec(3'd2, 1, 32'h800, 1, 32'hAA);
    lookup("R8 wrap youngest", 32'h500, 4'd9, 1, 0, 32'h88);
    lookup("R8 wrap youngest", 32'h500, 4'd10, 1, 0, 32'h99);
    lookup("R8 before wrap", 32'h500, 4'd8, 1, 0, 32'h55);
    lookup("R8 before wrap", 32'h500, 4'd6, 1, 0, 32'h55);
    lookup("R8 none older", 32'h500, 4'd5, 0, 0, 32'h0);
    lookup("R8 full range", 32'h100, 4'd11, 1, 0, 32'hD3);
    lookup("R8 position behind head", 32'h100, 4'd2, 0, 0, 32'h0);
    lookup("R9 stale entry not forwarded", 32'h300, 4'd6, 1, 0, 32'hE4);

    exp_addr[0] = 32'h100; exp_data[0] = 32'hD3;
    exp_addr[1] = 32'h300; exp_data[1] = 32'hE4;
    exp_addr[2] = 32'h500; exp_data[2] = 32'h55;
    exp_addr[3] = 32'h600; exp_data[3] = 32'h66;
    exp_addr[4] = 32'h700; exp_data[4] = 32'h77;
    exp_addr[5] = 32'h500; exp_data[5] = 32'h88;
    exp_addr[6] = 32'h500; exp_data[6] = 32'h99;
    exp_addr[7] = 32'h800; exp_data[7] = 32'hAA;
    drain(8, 8);
    @(negedge clk);
    check("R4 empty after drain", {empty, full, mem_valid}, 3'b100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule